// File: doc/BRIEF.md
# Parallel Port FIFO Service Controller

This block buffers bytes coming from a parallel peripheral toward the host in a 16-entry byte FIFO. It decides when to ask the host for service. With DMA enabled it drives a request line. With DMA disabled it drives an interrupt for programmed I/O transfers. The host steers service with three control inputs: a direction bit, a DMA-enable bit and a service-inhibit bit (`svc_intr`, written through a strobe). It also programs a 4-bit threshold field that sets how full the FIFO must be before a programmed-I/O interrupt fires.

Bytes enter on a valid/ready stream (`in_valid`/`in_ready`). A byte is accepted only in a cycle where both are high. `in_ready` is low while the FIFO is full or still disabled, and an upstream source must then hold its byte. Bytes leave on `out_valid`, and a host read is `out_ready` or a DMA acknowledge in a cycle with `out_valid` high. A terminal-count strobe ends a DMA transfer: it sets `svc_intr` and raises an interrupt. Back-to-back DMA service is capped at 32 acknowledged cycles, after which the request is released for one cycle so that other bus users are not starved.

Top module: `ppfifo_svc`

## Requirements
- R1: After reset, `dma_req`=0, `irq`=0, `fifo_en`=0, `svc_intr`=1, `fifo_level`=0, `in_ready`=0 and `out_valid`=0.
- R2: `fifo_en` becomes 1 at the clock edge where the host first writes `svc_intr`=0 and stays 1 until reset. While `fifo_en`=0, `in_ready` and `out_valid` are 0 and the level does not change.
- R3: The FIFO holds 16 bytes and returns them in arrival order. When full, `in_ready` is 0 and the level stays 16. A read when empty changes nothing and the level stays 0.
- R4: `dma_req` is 1 exactly when direction is FIFO-to-host (`dir_rev`=1), `dma_en`=1, `svc_intr`=0, the FIFO holds at least one byte and the burst cap is not in force.
- R5: When a read empties the FIFO, `dma_req` drops. It returns as soon as one byte is stored again, with no host action.
- R6: A `tc` strobe sets `svc_intr` and `irq` at the next edge, and `dma_req` stays 0. A host write of `svc_intr`=0 clears the terminal-count interrupt, and the request returns if data is present. `tc` wins over a same-cycle host write.
- R7: After 32 consecutive cycles with both `dma_req` and `dma_ack` high, `dma_req` is 0 for exactly one cycle and then returns. The run counter restarts whenever `dma_req` is 0.
- R8: In programmed I/O (`dir_rev`=1, `dma_en`=0, `svc_intr`=0), `irq` is 1 while the level is at least 16 − E. E = `thr_field`+1, limited to 15. So field 11 gives level ≥ 4, fields 14 and 15 give level ≥ 1, and field 0 gives level ≥ 15.
- R9: With `dir_rev`=0, `dma_req` and the programmed-I/O interrupt stay 0.
- R10: `svc_intr`=1 holds off both `dma_req` and the programmed-I/O interrupt. `dma_en`=1 holds off the programmed-I/O interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_field | input | 4 | Programmed threshold (effective value is field + 1) |
| dir_rev | input | 1 | 1 = FIFO-to-host direction |
| dma_en | input | 1 | DMA mode select |
| svc_wr | input | 1 | Write strobe for the service-inhibit bit |
| svc_wdata | input | 1 | Value written to the service-inhibit bit |
| in_valid | input | 1 | Peripheral byte valid |
| in_ready | output | 1 | FIFO can take a byte |
| in_data | input | 8 | Peripheral byte |
| out_ready | input | 1 | Programmed-I/O read strobe |
| out_valid | output | 1 | FIFO has a byte for the host |
| out_data | output | 8 | Head byte of the FIFO |
| dma_ack | input | 1 | Host DMA cycle (also reads a byte) |
| tc | input | 1 | Terminal-count strobe |
| dma_req | output | 1 | DMA service request |
| irq | output | 1 | Interrupt, level-sensitive |
| svc_intr | output | 1 | Current service-inhibit bit |
| fifo_en | output | 1 | FIFO enabled |
| fifo_level | output | 5 | Bytes stored (0 to 16) |

## Verification
All state (level, `svc_intr`, terminal-count flag, burst counter, enable) is registered, and every output is a combinational function of that state. So a push, read, `tc` or `svc_intr` write applied before an edge is visible just after that edge: one cycle of latency. A change of `thr_field`, `dma_en` or `dir_rev` reaches `irq` and `dma_req` in the same cycle. The bench drives inputs 5 ns after a rising edge and samples 5 ns after the next rising edge. For threshold changes it samples 1 ns after the drive. The burst-cap check samples `dma_req` before each of the 32 acknowledged edges, then once in the released cycle and once after it.

// File: rtl/ppfs_pkg.sv
package ppfs_pkg;
  // Occupancy at which a programmed-I/O interrupt fires for a given field.
  function automatic int unsigned ppfs_level(input int unsigned field, input int unsigned depth);
    int unsigned eff;
    eff = field + 1;
    if (eff > depth - 1) eff = depth - 1;
    return depth - eff;
  endfunction
endpackage

// File: rtl/ppfs_fifo.sv
module ppfs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          pop_req,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, pop;

  assign in_ready  = en && (count != CW'(DEPTH));
  assign out_valid = en && (count != '0);
  assign push      = in_valid && in_ready;
  assign pop       = pop_req && out_valid;
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_full_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !pop_req) |=> (count == CW'(DEPTH)));
  p_empty_read_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !in_valid) |=> (count == '0));
  p_disabled_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));
endmodule

// File: rtl/ppfs_dma_ctl.sv
module ppfs_dma_ctl #(
  parameter int BURST_MAX = 32,
  localparam int BW = $clog2(BURST_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic has_data,
  input  logic dma_ack,
  output logic dma_req
);
  logic [BW-1:0] burst_q;
  logic          cap_hit;

  assign cap_hit = (burst_q == BW'(BURST_MAX));
  assign dma_req = active && has_data && !cap_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)            burst_q <= '0;
    else if (!dma_req)     burst_q <= '0;
    else if (dma_ack)      burst_q <= burst_q + 1'b1;
  end

  p_req_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (active && has_data));
  p_cap_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (burst_q == '0));
endmodule

// File: rtl/ppfs_irq_ctl.sv
module ppfs_irq_ctl
  import ppfs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int TW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] thr_field,
  input  logic [CW-1:0] count,
  input  logic          pio_active,
  input  logic          tc_flag,
  output logic          irq
);
  logic [CW-1:0] level;
  logic          pio_irq;

  assign level   = CW'(ppfs_level(int'(thr_field), DEPTH));
  assign pio_irq = pio_active && (count >= level);
  assign irq     = pio_irq || tc_flag;

  p_pio_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pio_active && !tc_flag) |-> !irq);
endmodule

// File: rtl/ppfifo_svc.sv
module ppfifo_svc #(
  parameter int W         = 8,
  parameter int DEPTH     = 16,
  parameter int BURST_MAX = 32,
  localparam int TW       = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int RW       = $clog2(BURST_MAX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] thr_field,
  input  logic          dir_rev,
  input  logic          dma_en,
  input  logic          svc_wr,
  input  logic          svc_wdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          dma_ack,
  input  logic          tc,
  output logic          dma_req,
  output logic          irq,
  output logic          svc_intr,
  output logic          fifo_en,
  output logic [CW-1:0] fifo_level
);
  logic svc_q, tc_flag_q, en_q;
  logic dma_active, pio_active;

  assign svc_intr   = svc_q;
  assign fifo_en    = en_q;
  assign dma_active = dir_rev && dma_en && !svc_q;
  assign pio_active = dir_rev && !dma_en && !svc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_q     <= 1'b1;
      tc_flag_q <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      if (tc) begin
        svc_q     <= 1'b1;
        tc_flag_q <= 1'b1;
      end else if (svc_wr) begin
        svc_q <= svc_wdata;
        if (!svc_wdata) tc_flag_q <= 1'b0;
      end
      if (svc_wr && !svc_wdata) en_q <= 1'b1;
    end
  end

  ppfs_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .en(en_q),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pop_req(out_ready || dma_ack), .out_valid(out_valid), .out_data(out_data),
    .count(fifo_level)
  );

  ppfs_dma_ctl #(.BURST_MAX(BURST_MAX)) u_dma (
    .clk(clk), .rst_n(rst_n), .active(dma_active), .has_data(out_valid),
    .dma_ack(dma_ack), .dma_req(dma_req)
  );

  ppfs_irq_ctl #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .thr_field(thr_field), .count(fifo_level),
    .pio_active(pio_active), .tc_flag(tc_flag_q), .irq(irq)
  );

  // Independent run-length monitor for the burst cap.
  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n || !dma_req) run_q <= '0;
    else if (dma_ack)       run_q <= run_q + 1'b1;
  end

  p_burst_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(BURST_MAX));
  p_tc_sets_svc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> (svc_intr && irq && !dma_req));
  p_svc_blocks_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    svc_intr |-> !dma_req);
  p_dir_blocks_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_rev |-> !dma_req);
  p_enable_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en |=> fifo_en);
endmodule

// File: tb/ppfifo_svc_tb_top.sv
module ppfifo_svc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] thr_field;
  logic       dir_rev, dma_en, svc_wr, svc_wdata;
  logic       in_valid, in_ready, out_ready, out_valid;
  logic [7:0] in_data, out_data;
  logic       dma_ack, tc, dma_req, irq, svc_intr, fifo_en;
  logic [4:0] fifo_level;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ppfifo_svc dut_i (
    .clk(clk), .rst_n(rst_n), .thr_field(thr_field), .dir_rev(dir_rev),
    .dma_en(dma_en), .svc_wr(svc_wr), .svc_wdata(svc_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .dma_ack(dma_ack), .tc(tc), .dma_req(dma_req), .irq(irq),
    .svc_intr(svc_intr), .fifo_en(fifo_en), .fifo_level(fifo_level)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic pio_read();
    out_ready = 1'b1;
    tick();
    out_ready = 1'b0;
  endtask

  task automatic write_svc(input logic v);
    svc_wr = 1'b1; svc_wdata = v;
    tick();
    svc_wr = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 17; i++) pio_read();
  endtask

  task automatic t_reset();
    check("R1 dma_req", dma_req, 0);
    check("R1 irq", irq, 0);
    check("R1 fifo_en", fifo_en, 0);
    check("R1 svc_intr", svc_intr, 1);
    check("R1 level", fifo_level, 0);
    check("R1 in_ready", in_ready, 0);
    check("R1 out_valid", out_valid, 0);
  endtask

  task automatic t_enable();
    push(8'h11);
    check("R2 disabled write ignored", fifo_level, 0);
    write_svc(1'b0);
    check("R2 fifo_en set", fifo_en, 1);
    check("R2 in_ready", in_ready, 1);
    write_svc(1'b1);
    check("R2 fifo_en sticky", fifo_en, 1);
    write_svc(1'b0);
  endtask

  task automatic t_fifo();
    dma_en = 1'b0;
    for (int i = 0; i < 16; i++) push(8'hA0 + 8'(i));
    check("R3 full level", fifo_level, 16);
    check("R3 full in_ready", in_ready, 0);
    push(8'h55);
    check("R3 full write ignored", fifo_level, 16);
    for (int i = 0; i < 16; i++) begin
      check("R3 order", out_data, 8'hA0 + i);
      pio_read();
    end
    check("R3 empty level", fifo_level, 0);
    pio_read();
    check("R3 empty read ignored", fifo_level, 0);
  endtask

  task automatic t_dma_basic();
    dma_en = 1'b1;
    tick();
    check("R4 no data no req", dma_req, 0);
    push(8'h01);
    check("R4 req with one byte", dma_req, 1);
    dma_ack = 1'b1; tick(); dma_ack = 1'b0;
    check("R5 req drops on empty", dma_req, 0);
    push(8'h02);
    check("R5 req returns", dma_req, 1);
    drain();
  endtask

  task automatic t_tc();
    push(8'h10); push(8'h11); push(8'h12);
    check("R6 req before tc", dma_req, 1);
    dma_ack = 1'b1; tc = 1'b1; tick(); dma_ack = 1'b0; tc = 1'b0;
    check("R6 svc set", svc_intr, 1);
    check("R6 irq set", irq, 1);
    check("R6 req off", dma_req, 0);
    push(8'h13);
    check("R6 req stays off with data", dma_req, 0);
    check("R6 irq holds", irq, 1);
    svc_wr = 1'b1; svc_wdata = 1'b0; tc = 1'b1; tick(); svc_wr = 1'b0; tc = 1'b0;
    check("R6 tc wins over write", svc_intr, 1);
    write_svc(1'b0);
    check("R6 irq cleared", irq, 0);
    check("R6 req back", dma_req, 1);
    drain();
  endtask

  task automatic t_burst();
    int bad = 0;
    for (int i = 0; i < 8; i++) push(8'h20 + 8'(i));
    for (int i = 0; i < 32; i++) begin
      if (dma_req !== 1'b1) bad++;
      in_valid = 1'b1; in_data = 8'h30; dma_ack = 1'b1;
      tick();
    end
    in_valid = 1'b0; dma_ack = 1'b0;
    check("R7 req high during 32 acks (misses)", bad, 0);
    check("R7 req released", dma_req, 0);
    check("R7 level kept", fifo_level, 8);
    tick();
    check("R7 req returns after one cycle", dma_req, 1);
    drain();
  endtask

  task automatic t_pio();
    dma_en = 1'b0;
    thr_field = 4'd11;
    push(8'h1); push(8'h2); push(8'h3);
    check("R8 field11 level3", irq, 0);
    push(8'h4);
    check("R8 field11 level4", irq, 1);
    pio_read();
    check("R8 field11 back to 3", irq, 0);
    drain();
    thr_field = 4'd15;
    push(8'h5);
    check("R8 field15 level1", irq, 1);
    thr_field = 4'd14; #1;
    check("R8 field14 level1", irq, 1);
    thr_field = 4'd0; #1;
    check("R8 field0 level1", irq, 0);
    for (int i = 0; i < 13; i++) push(8'h6);
    check("R8 field0 level14", irq, 0);
    push(8'h7);
    check("R8 field0 level15", irq, 1);
  endtask

  task automatic t_block();
    write_svc(1'b1);
    check("R10 svc blocks pio irq", irq, 0);
    dma_en = 1'b1; #1;
    check("R10 svc blocks req", dma_req, 0);
    write_svc(1'b0);
    check("R10 dma_en blocks pio irq", irq, 0);
    check("R4 req with data", dma_req, 1);
    dir_rev = 1'b0; #1;
    check("R9 fwd no req", dma_req, 0);
    dma_en = 1'b0; #1;
    check("R9 fwd no pio irq", irq, 0);
    dir_rev = 1'b1;
    drain();
  endtask

  initial begin
    rst_n = 1'b0; thr_field = 4'd0; dir_rev = 1'b1; dma_en = 1'b0;
    svc_wr = 1'b0; svc_wdata = 1'b0; in_valid = 1'b0; in_data = '0;
    out_ready = 1'b0; dma_ack = 1'b0; tc = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_enable();
    t_fifo();
    t_dma_basic();
    t_tc();
    t_burst();
    t_pio();
    t_block();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule